// File: doc/BRIEF.md
# Byte-Lane Write Strobe and Top-Region Select Decoder

This block controls a 64-bit wide memory built from eight byte-wide banks, one bank per byte lane: bank k carries data bits 8k+7 down to 8k. From the memory-versus-IO qualifier and the write-versus-read qualifier it forms an active-low memory-write command and an active-low memory-read command. The write command is gated with eight active-low byte enables so that each bank receives its own write strobe. Every combination of the eight lanes may be written in one cycle.

The address is decoded in two stages. The first stage forms an intermediate select from address bits 19 to 28. The second stage combines that term with bits 29 to 31 to give an active-low chip enable. This enable covers the 512 KB region FFF80000h to FFFFFFFFh. Address bits 3 to 18 form the 16-bit word address shared by all banks. Bits 0 to 2 select a byte within the 64-bit word and are not decoded here. All outputs are registered. The block has no data path of its own, so every pin is a plain control signal with no handshake.

Top module: `lane_strobe_decoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next outputs are all eight `bank_wr_n` bits high, `chip_en_n` high, `rd_oe_n` high and `bank_addr` zero.
- R2: No `bank_wr_n` bit goes low unless `mem_sel`=1 (memory cycle) and `wr_sel`=1 (write) were both presented.
- R3: With a memory write to an address inside the region, `bank_wr_n[k]` is low exactly when `byte_en_n[k]` is low. Bit k is the lane for data bits 8k+7 down to 8k.
- R4: If any of address bits 19 to 28 is 0, the intermediate select is inactive and `chip_en_n` stays high, even when bits 29 to 31 are all 1.
- R5: `chip_en_n` is low exactly when address bits 19 through 31 are all 1. If bits 29 to 31 are not all 1, it stays high even when bits 19 to 28 are all 1.
- R6: `rd_oe_n` is low exactly when `mem_sel`=1 and `wr_sel`=0, whatever the address.
- R7: `bank_addr` equals address bits 18 down to 3. Address bits 2 to 0 have no effect on any output.
- R8: Each output reflects the inputs sampled at the previous rising edge and does not change between edges.
- R9: Any byte-enable pattern, including sparse and non-contiguous ones, reaches the strobes unaltered.
- R10: An address below FFF80000h leaves `chip_en_n` and all eight `bank_wr_n` bits high, even with all byte enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_sel | input | 1 | 1 = memory cycle, 0 = IO cycle |
| wr_sel | input | 1 | 1 = write, 0 = read |
| byte_en_n | input | 8 | Active-low byte-lane enables, bit k = lane k |
| addr | input | 32 | Byte address |
| bank_wr_n | output | 8 | Active-low per-bank write strobes, registered |
| chip_en_n | output | 1 | Active-low region chip enable, registered |
| rd_oe_n | output | 1 | Active-low output enable for all banks, registered |
| bank_addr | output | 16 | Word address for every bank, registered |

## Verification
Every result comes out of a single output register, so each output is due exactly one rising edge after the inputs that produce it. The bench changes inputs on the falling edge. It reads outputs on the next falling edge, half a period after the capturing rising edge. It also checks once before that edge that the outputs still hold the earlier values. The reset check applies the same rule: the idle levels are read on the falling edge after the first edge with reset high.

// File: rtl/lane_strobe_pkg.sv
package lane_strobe_pkg;
  localparam int unsigned LS_BANKS       = 8;
  localparam int unsigned LS_ADDR_W      = 32;
  localparam int unsigned LS_REGION_LSB  = 19;
  localparam int unsigned LS_SPLIT_BIT   = 29;
  localparam int unsigned LS_WORD_LSB    = $clog2(LS_BANKS);
  localparam int unsigned LS_WORD_W      = LS_REGION_LSB - LS_WORD_LSB;

  typedef struct packed {
    logic wr_cmd_n;
    logic rd_cmd_n;
  } bus_cmd_t;
endpackage

// File: rtl/bus_cmd_decode.sv
module bus_cmd_decode
  import lane_strobe_pkg::*;
(
  input  logic     mem_sel,
  input  logic     wr_sel,
  output bus_cmd_t cmd
);
  always_comb begin
    cmd.wr_cmd_n = ~(mem_sel & wr_sel);
    cmd.rd_cmd_n = ~(mem_sel & ~wr_sel);
  end
endmodule

// File: rtl/region_decode.sv
module region_decode #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned REGION_LSB = 19,
  parameter int unsigned SPLIT_BIT  = 29
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              mid_sel_n,
  output logic              ce_n
);
  localparam int unsigned LOW_W  = SPLIT_BIT - REGION_LSB;
  localparam int unsigned HIGH_W = ADDR_W - SPLIT_BIT;

  logic [LOW_W-1:0]  low_field;
  logic [HIGH_W-1:0] high_field;

  assign low_field  = addr[SPLIT_BIT-1:REGION_LSB];
  assign high_field = addr[ADDR_W-1:SPLIT_BIT];

  // stage one: intermediate term over the lower decoded field
  always_comb mid_sel_n = ~(&low_field);

  // stage two: intermediate term combined with the top field
  always_comb ce_n = ~(~mid_sel_n & (&high_field));
endmodule

// File: rtl/lane_strobe_gen.sv
module lane_strobe_gen #(
  parameter int unsigned BANKS = 8
) (
  input  logic [BANKS-1:0] byte_en_n,
  input  logic             wr_cmd_n,
  input  logic             ce_n,
  output logic [BANKS-1:0] wr_n
);
  for (genvar k = 0; k < BANKS; k++) begin : g_lane
    assign wr_n[k] = byte_en_n[k] | wr_cmd_n | ce_n;
  end
endmodule

// File: rtl/lane_strobe_decoder.sv
module lane_strobe_decoder
  import lane_strobe_pkg::*;
#(
  parameter int unsigned BANKS      = LS_BANKS,
  parameter int unsigned ADDR_W     = LS_ADDR_W,
  parameter int unsigned REGION_LSB = LS_REGION_LSB,
  parameter int unsigned SPLIT_BIT  = LS_SPLIT_BIT,
  localparam int unsigned WORD_LSB  = $clog2(BANKS),
  localparam int unsigned WORD_W    = REGION_LSB - WORD_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_sel,
  input  logic              wr_sel,
  input  logic [BANKS-1:0]  byte_en_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [BANKS-1:0]  bank_wr_n,
  output logic              chip_en_n,
  output logic              rd_oe_n,
  output logic [WORD_W-1:0] bank_addr
);
  bus_cmd_t         cmd;
  logic             mid_sel_n;
  logic             ce_n_c;
  logic [BANKS-1:0] wr_n_c;

  bus_cmd_decode u_cmd (
    .mem_sel (mem_sel),
    .wr_sel  (wr_sel),
    .cmd     (cmd)
  );

  region_decode #(
    .ADDR_W     (ADDR_W),
    .REGION_LSB (REGION_LSB),
    .SPLIT_BIT  (SPLIT_BIT)
  ) u_region (
    .addr      (addr),
    .mid_sel_n (mid_sel_n),
    .ce_n      (ce_n_c)
  );

  lane_strobe_gen #(
    .BANKS (BANKS)
  ) u_lanes (
    .byte_en_n (byte_en_n),
    .wr_cmd_n  (cmd.wr_cmd_n),
    .ce_n      (ce_n_c),
    .wr_n      (wr_n_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_wr_n <= '1;
      chip_en_n <= 1'b1;
      rd_oe_n   <= 1'b1;
      bank_addr <= '0;
    end else begin
      bank_wr_n <= wr_n_c;
      chip_en_n <= ce_n_c;
      rd_oe_n   <= cmd.rd_cmd_n;
      bank_addr <= addr[REGION_LSB-1:WORD_LSB];
    end
  end
endmodule

// File: rtl/lane_strobe_decoder_chk.sv
module lane_strobe_decoder_chk #(
  parameter int unsigned BANKS      = 8,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned REGION_LSB = 19,
  parameter int unsigned WORD_W     = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_sel,
  input logic              wr_sel,
  input logic [BANKS-1:0]  byte_en_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BANKS-1:0]  bank_wr_n,
  input logic              chip_en_n,
  input logic              rd_oe_n,
  input logic [WORD_W-1:0] bank_addr
);
  localparam int unsigned WORD_LSB = $clog2(BANKS);
  logic in_top;
  assign in_top = &addr[ADDR_W-1:REGION_LSB];

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (&bank_wr_n && chip_en_n && rd_oe_n)); // R1
  AST_NO_STROBE_OFF_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(mem_sel && wr_sel) |=> &bank_wr_n); // R2
  AST_LANE_FOLLOWS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (mem_sel && wr_sel && in_top) |=> bank_wr_n == $past(byte_en_n)); // R3
  AST_CE_TOP_REGION: assert property (@(posedge clk) disable iff (rst)
    in_top |=> !chip_en_n); // R5
  AST_LOW_ADDR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_top |=> (chip_en_n && &bank_wr_n)); // R10
  AST_READ_OE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rd_oe_n == !$past(mem_sel && !wr_sel)); // R6
  AST_WORD_ADDR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> bank_addr == $past(addr[REGION_LSB-1:WORD_LSB])); // R7
endmodule

bind lane_strobe_decoder lane_strobe_decoder_chk #(
  .BANKS      (BANKS),
  .ADDR_W     (ADDR_W),
  .REGION_LSB (REGION_LSB),
  .WORD_W     (WORD_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_sel   (mem_sel),
  .wr_sel    (wr_sel),
  .byte_en_n (byte_en_n),
  .addr      (addr),
  .bank_wr_n (bank_wr_n),
  .chip_en_n (chip_en_n),
  .rd_oe_n   (rd_oe_n),
  .bank_addr (bank_addr)
);

// File: tb/test_lane_strobe_decoder.sv
`timescale 1ns/1ps
module test_lane_strobe_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_sel = 1'b0;
  logic        wr_sel = 1'b0;
  logic [7:0]  byte_en_n = 8'hFF;
  logic [31:0] addr = '0;
  logic [7:0]  bank_wr_n;
  logic        chip_en_n;
  logic        rd_oe_n;
  logic [15:0] bank_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lane_strobe_decoder i_lane_strobe_decoder (
    .clk       (clk),
    .rst       (rst),
    .mem_sel   (mem_sel),
    .wr_sel    (wr_sel),
    .byte_en_n (byte_en_n),
    .addr      (addr),
    .bank_wr_n (bank_wr_n),
    .chip_en_n (chip_en_n),
    .rd_oe_n   (rd_oe_n),
    .bank_addr (bank_addr)
  );

  // {mem, wr, be_n[7:0], addr[31:0], exp_wr_n[7:0], exp_ce_n, exp_oe_n}
  localparam int NVEC = 12;
  localparam logic [51:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 8'h00, 32'hFFF80000, 8'h00, 1'b0, 1'b1}, // R3 R5 all lanes
    {1'b1, 1'b1, 8'hFE, 32'hFFFFFFFF, 8'hFE, 1'b0, 1'b1}, // R3 single lane 0
    {1'b1, 1'b1, 8'h5A, 32'hFFF81238, 8'h5A, 1'b0, 1'b1}, // R9 sparse
    {1'b1, 1'b1, 8'h00, 32'hFFF7FFFF, 8'hFF, 1'b1, 1'b1}, // R10 R4 just below
    {1'b1, 1'b1, 8'h00, 32'hEFFFFFFF, 8'hFF, 1'b1, 1'b1}, // R4 bit 28 low
    {1'b1, 1'b1, 8'h00, 32'h1FF80000, 8'hFF, 1'b1, 1'b1}, // R5 top bits low
    {1'b1, 1'b0, 8'h00, 32'hFFF80000, 8'hFF, 1'b0, 1'b0}, // R2 R6 mem read
    {1'b0, 1'b1, 8'h00, 32'hFFF80000, 8'hFF, 1'b0, 1'b1}, // R2 IO write
    {1'b0, 1'b0, 8'h00, 32'hFFFFFFF8, 8'hFF, 1'b0, 1'b1}, // R6 IO read
    {1'b1, 1'b0, 8'hFF, 32'h00000000, 8'hFF, 1'b1, 1'b0}, // R6 low read
    {1'b1, 1'b1, 8'hFF, 32'hFFF80007, 8'hFF, 1'b0, 1'b1}, // R3 no lanes
    {1'b1, 1'b1, 8'h7F, 32'hFFFC0005, 8'h7F, 1'b0, 1'b1}  // R9 seven lanes
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [51:0] v);
    mem_sel   = v[51];
    wr_sel    = v[50];
    byte_en_n = v[49:42];
    addr      = v[41:10];
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset with an active write presented
    drive({1'b1, 1'b1, 8'h00, 32'hFFF80000, 10'h0});
    @(posedge clk); @(negedge clk);
    chk("R1 wr_n", {24'h0, bank_wr_n}, 32'hFF);
    chk("R1 ce_n", {31'h0, chip_en_n}, 32'h1);
    chk("R1 oe_n", {31'h0, rd_oe_n}, 32'h1);
    chk("R1 bank_addr", {16'h0, bank_addr}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i]);
      @(posedge clk); @(negedge clk);
      chk("R3 R9 R10 wr_n", {24'h0, bank_wr_n}, {24'h0, VEC[i][9:2]});
      chk("R4 R5 ce_n", {31'h0, chip_en_n}, {31'h0, VEC[i][1]});
      chk("R6 oe_n", {31'h0, rd_oe_n}, {31'h0, VEC[i][0]});
      chk("R7 bank_addr", {16'h0, bank_addr}, {16'h0, VEC[i][28:13]});
    end

    // R8: outputs hold until the next rising edge
    drive({1'b1, 1'b1, 8'h3C, 32'hFFF80010, 10'h0});
    @(posedge clk); @(negedge clk);
    drive({1'b1, 1'b0, 8'hFF, 32'h00000000, 10'h0});
    #1;
    chk("R8 hold wr_n", {24'h0, bank_wr_n}, 32'h3C);
    chk("R8 hold ce_n", {31'h0, chip_en_n}, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R8 update ce_n", {31'h0, chip_en_n}, 32'h1);
    chk("R8 update oe_n", {31'h0, rd_oe_n}, 32'h0);

    // R7: low three address bits change nothing
    drive({1'b1, 1'b1, 8'hA5, 32'hFFFABCD0, 10'h0});
    @(posedge clk); @(negedge clk);
    drive({1'b1, 1'b1, 8'hA5, 32'hFFFABCD7, 10'h0});
    @(posedge clk); @(negedge clk);
    chk("R7 bank_addr", {16'h0, bank_addr}, 32'h579A);
    chk("R7 wr_n", {24'h0, bank_wr_n}, 32'hA5);

    // R1: reset mid-run forces idle levels
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 mid wr_n", {24'h0, bank_wr_n}, 32'hFF);
    chk("R1 mid ce_n", {31'h0, chip_en_n}, 32'h1);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule